// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block provides three independent 16-bit down-counters behind a byte-wide register interface. Address 3 is the control port, and addresses 0 to 2 are the data ports of channels 0 to 2. A control word selects a channel. It then either freezes that channel's current count into a holding register for a stable two-byte read, or sets the channel's counting mode. Every count load and every count read is a pair of bytes, low byte first. The counters step once per tick. The tick is derived from the system clock by a parameterised divider. The nominal tick rate is 1,193,180 Hz, so the default division suits a clock near 100 MHz.

Each channel drives an output level. Mode 0 raises the output once at terminal count and leaves it high. Mode 2 is a rate generator: the output goes low for one tick at terminal count, and the count reloads. Mode 3 is a square wave: the output is high for the larger half of the reload period and low for the smaller half. A read of address 3 returns a status byte that carries channel 2's output level. Unsupported control words are refused, and `cfg_err` pulses for one cycle.

Each channel contains three state machines:
- **Run machine.** States are STOP, COUNT and DONE.
  - A low-byte write moves any state to STOP.
  - A high-byte write moves any state to COUNT when the new reload value is nonzero, and otherwise to STOP.
  - COUNT moves to DONE at terminal count in mode 0.
  - COUNT reloads and stays in COUNT in modes 2 and 3.
- **Write-byte sequencer.** States are LO and HI. A data write moves LO to HI and HI to LO. An accepted mode setting returns it to LO.
- **Read-byte sequencer.** States are LO and HI. A data read moves LO to HI. From HI, a data read returns to LO and releases any held latch. A latch command or an accepted mode setting returns it to LO.

Top module: `pit3_timer`

## Requirements
- R1: After reset, all three outputs are low, `cfg_err` is low, and a read of address 3 returns 0x00.
- R2: A control word is decoded as follows: bits 7:6 select the channel, bits 5:4 give the access code (00 = latch, 11 = low-then-high), bits 3:1 give the mode, and bit 0 is the BCD flag. A channel select of 3 is refused, and `cfg_err` is high in the cycle after the write. A latch command to channels 0 to 2 never raises `cfg_err`.
- R3: Any of the following non-latch control words is refused, raises `cfg_err` in the next cycle, and leaves the channel's previous mode in force: access code 01 or 10, a mode other than 0, 2 or 3, or a set BCD flag.
- R4: A latch command copies the live count into a holding register and sets the read sequence to the low byte. The next two reads return the held low byte and then the held high byte. The second of these reads releases the latch.
- R5: A latch command issued while a latch is held is ignored, and the earlier held value is still returned.
- R6: With no latch held, data reads return the live count, low byte first and then high byte.
- R7: Writing the low byte replaces count bits 7:0, stops counting, and drives the channel output low in the next cycle.
- R8: Writing the high byte completes the reload value. A nonzero value starts counting, and the output goes high at once in modes 2 and 3. A zero value leaves the channel stopped.
- R9: In mode 0 with reload N, the output goes high at the N-th tick after the load and then stays high.
- R10: In mode 2, the output is low for exactly one tick period once every N ticks.
- R11: In mode 3, the output is high for ceil(N/2) ticks and low for floor(N/2) ticks.
- R12: A tick occurs once every `TICK_DIV` clock cycles. A channel output changes only after a tick or a register write.
- R13: A read of address 3 returns channel 2's output on bit 5 and zero on every other bit, and has no side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; advances the read sequencer on data ports |
| addr | input | 2 | 0 to 2 select the channel data ports; 3 selects control (write) or status (read) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid combinationally for the current address |
| cnt_out | output | 3 | Output level of each channel |
| cfg_err | output | 1 | One-cycle pulse after a refused control word |

## Verification
The bench builds the timer with `TICK_DIV` = 4. This makes one tick four clock cycles, so whole mode-2 and mode-3 periods fit in a few dozen cycles. With that setting, the low pulse width, the rate-generator period and the uneven halves of an odd square wave become exact cycle counts measured at the outputs. The mode-0 terminal-count window can also be bounded to within one tick. Stopped channels hold their count still, which lets the latch, the repeated latch and the live-read ordering be checked against known byte values.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int CTRL_SEL_HI  = 7;
    localparam int CTRL_SEL_LO  = 6;
    localparam int CTRL_ACC_HI  = 5;
    localparam int CTRL_ACC_LO  = 4;
    localparam int CTRL_MODE_HI = 3;
    localparam int CTRL_MODE_LO = 1;
    localparam int CTRL_BCD     = 0;
    localparam int STATUS_BIT   = 5;

    typedef enum logic [2:0] {
        MODE_ONESHOT = 3'd0,
        MODE_RATE    = 3'd2,
        MODE_SQUARE  = 3'd3
    } mode_t;

    typedef enum logic {
        SEQ_LO = 1'b0,
        SEQ_HI = 1'b1
    } seq_t;

    typedef enum logic [1:0] {
        RUN_STOP  = 2'd0,
        RUN_COUNT = 2'd1,
        RUN_DONE  = 2'd2
    } run_t;
endpackage

// File: rtl/pit_tick_div.sv
module pit_tick_div #(
    parameter int TICK_DIV = 84
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

    logic [DW-1:0] div_q;

    assign tick = (div_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || tick) div_q <= '0;
        else                div_q <= div_q + DW'(1);
    end
endmodule

// File: rtl/pit_ctrl_decode.sv
module pit_ctrl_decode
    import pit_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic           ctrl_we,
    input  logic [7:0]     ctrl_word,
    output logic [NCH-1:0] cfg_we,
    output logic [NCH-1:0] latch_req,
    output logic           bad_word
);
    localparam int SW = 2;

    logic [SW-1:0] sel;
    logic [1:0]    acc;
    logic [2:0]    md;
    logic          sel_bad, is_latch, cfg_ok;

    always_comb begin
        sel      = ctrl_word[CTRL_SEL_HI:CTRL_SEL_LO];
        acc      = ctrl_word[CTRL_ACC_HI:CTRL_ACC_LO];
        md       = ctrl_word[CTRL_MODE_HI:CTRL_MODE_LO];
        sel_bad  = (32'(sel) >= NCH);
        is_latch = (acc == 2'b00);
        cfg_ok   = (acc == 2'b11) && !ctrl_word[CTRL_BCD] &&
                   (md == MODE_ONESHOT || md == MODE_RATE || md == MODE_SQUARE);
        bad_word = ctrl_we && (sel_bad || (!is_latch && !cfg_ok));
    end

    for (genvar i = 0; i < NCH; i++) begin : g_sel
        assign latch_req[i] = ctrl_we && !sel_bad && (sel == SW'(i)) && is_latch;
        assign cfg_we[i]    = ctrl_we && !sel_bad && (sel == SW'(i)) && cfg_ok;
    end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_mode,
    input  logic          latch_req,
    input  logic          data_we,
    input  logic          data_re,
    input  logic [BW-1:0] wdata,
    output logic [BW-1:0] rdata,
    output logic          out
);
    localparam int CW = 2 * BW;

    run_t          run_q, run_d;
    seq_t          wr_q, rd_q;
    mode_t         mode_q;
    logic [CW-1:0] cnt_q, reload_q, hold_q, half_mark, new_reload;
    logic          held_q, out_q, lo_wr, hi_wr, term;

    always_comb begin
        lo_wr      = data_we && (wr_q == SEQ_LO);
        hi_wr      = data_we && (wr_q == SEQ_HI);
        new_reload = {wdata, cnt_q[BW-1:0]};
        term       = (cnt_q == CW'(1));
        half_mark  = (reload_q >> 1) + CW'(1);
    end

    // run state machine: next state
    always_comb begin
        run_d = run_q;
        if (lo_wr) begin
            run_d = RUN_STOP;
        end else if (hi_wr) begin
            run_d = (new_reload != '0) ? RUN_COUNT : RUN_STOP;
        end else begin
            unique case (run_q)
                RUN_STOP:  run_d = RUN_STOP;
                RUN_COUNT: if (tick && term && mode_q == MODE_ONESHOT) run_d = RUN_DONE;
                RUN_DONE:  run_d = RUN_DONE;
                default:   run_d = RUN_STOP;
            endcase
        end
    end

    // run state register
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= RUN_STOP;
        else        run_q <= run_d;
    end

    // sequencers, latch, count and output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q     <= SEQ_LO;
            rd_q     <= SEQ_LO;
            mode_q   <= MODE_ONESHOT;
            cnt_q    <= '0;
            reload_q <= '0;
            hold_q   <= '0;
            held_q   <= 1'b0;
            out_q    <= 1'b0;
        end else begin
            if (cfg_we) begin
                mode_q <= mode_t'(cfg_mode);
                wr_q   <= SEQ_LO;
                rd_q   <= SEQ_LO;
            end else if (latch_req && !held_q) begin
                held_q <= 1'b1;
                hold_q <= cnt_q;
                rd_q   <= SEQ_LO;
            end else if (data_re) begin
                unique case (rd_q)
                    SEQ_LO: rd_q <= SEQ_HI;
                    SEQ_HI: begin
                        rd_q   <= SEQ_LO;
                        held_q <= 1'b0;
                    end
                    default: rd_q <= SEQ_LO;
                endcase
            end

            if (lo_wr) begin
                cnt_q[BW-1:0] <= wdata;
                out_q         <= 1'b0;
                wr_q          <= SEQ_HI;
            end else if (hi_wr) begin
                cnt_q[CW-1:BW] <= wdata;
                reload_q       <= new_reload;
                wr_q           <= SEQ_LO;
                out_q          <= (mode_q != MODE_ONESHOT) && (new_reload != '0);
            end else if (run_q == RUN_COUNT && tick) begin
                unique case (mode_q)
                    MODE_ONESHOT: begin
                        cnt_q <= cnt_q - CW'(1);
                        if (term) out_q <= 1'b1;
                    end
                    MODE_RATE: begin
                        cnt_q <= term ? reload_q : cnt_q - CW'(1);
                        out_q <= !term;
                    end
                    MODE_SQUARE: begin
                        cnt_q <= term ? reload_q : cnt_q - CW'(1);
                        if (term || cnt_q == half_mark) out_q <= !out_q;
                    end
                    default: cnt_q <= cnt_q;
                endcase
            end
        end
    end

    always_comb begin
        unique case (rd_q)
            SEQ_LO:  rdata = held_q ? hold_q[BW-1:0]  : cnt_q[BW-1:0];
            SEQ_HI:  rdata = held_q ? hold_q[CW-1:BW] : cnt_q[CW-1:BW];
            default: rdata = '0;
        endcase
    end

    assign out = out_q;
endmodule

// File: rtl/pit3_timer.sv
module pit3_timer
    import pit_pkg::*;
#(
    parameter int TICK_DIV = 84
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic [2:0] cnt_out,
    output logic       cfg_err
);
    localparam int NCH = 3;
    localparam int BW  = 8;
    localparam logic [1:0] CTRL_ADDR = 2'd3;

    logic           tick, bad_word, ctrl_we;
    logic [NCH-1:0] cfg_we, latch_req;
    logic [BW-1:0]  ch_rd [NCH];

    assign ctrl_we = wr_en && (addr == CTRL_ADDR);

    pit_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    pit_ctrl_decode #(.NCH(NCH)) u_dec (
        .ctrl_we   (ctrl_we),
        .ctrl_word (wdata),
        .cfg_we    (cfg_we),
        .latch_req (latch_req),
        .bad_word  (bad_word)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pit_channel #(.BW(BW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .cfg_we    (cfg_we[i]),
            .cfg_mode  (wdata[CTRL_MODE_HI:CTRL_MODE_LO]),
            .latch_req (latch_req[i]),
            .data_we   (wr_en && addr == 2'(i)),
            .data_re   (rd_en && addr == 2'(i)),
            .wdata     (wdata),
            .rdata     (ch_rd[i]),
            .out       (cnt_out[i])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err <= 1'b0;
        else        cfg_err <= bad_word;
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            2'd0: rdata = ch_rd[0];
            2'd1: rdata = ch_rd[1];
            2'd2: rdata = ch_rd[2];
            2'd3: rdata[STATUS_BIT] = cnt_out[2];
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/pit3_timer_chk.sv
module pit3_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] addr,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic [2:0] cnt_out,
    input logic       cfg_err,
    input logic       tick
);
    logic ctl_wr;
    assign ctl_wr = wr_en && (addr == 2'd3);

    assert_err_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(ctl_wr));

    assert_readback_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wdata[7:6] == 2'b11) |=> cfg_err);

    assert_latch_ok_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wdata[7:6] != 2'b11 && wdata[5:4] == 2'b00) |=> !cfg_err);

    assert_bcd_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wdata[0] && wdata[5:4] != 2'b00) |=> cfg_err);

    assert_mode_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wdata[5:4] == 2'b11 && (wdata[3:1] == 3'd1 || wdata[3:1] > 3'd3)) |=> cfg_err);

    assert_status_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 2'd3) |-> (rdata[5] == cnt_out[2] && rdata[7:6] == 2'b00 && rdata[4:0] == 5'd0));

    for (genvar i = 0; i < 3; i++) begin : g_out
        assert_out_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_out[i] != $past(cnt_out[i])) |-> ($past(tick) || $past(wr_en)));
    end
endmodule

bind pit3_timer pit3_timer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .cnt_out (cnt_out),
    .cfg_err (cfg_err),
    .tick    (tick)
);

// File: tb/pit3_timer_test.sv
module pit3_timer_test;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [2:0] cnt_out;
    logic       cfg_err;
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    pit3_timer #(.TICK_DIV(DIV)) uut (
        .clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata, .cnt_out, .cfg_err
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic wait_lvl(input int ch, input logic v, output int n);
        n = 0;
        while (cnt_out[ch] !== v && n < 400) begin @(negedge clk); n++; end
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk(cnt_out == 3'b000, "R1 outputs", cnt_out, 0);
        chk(cfg_err == 1'b0, "R1 cfg_err", cfg_err, 0);
        rd(2'd3, d);
        chk(d == 8'h00, "R1 status", d, 0);
    endtask

    task automatic t_errors;
        wr(2'd3, 8'hC0); chk(cfg_err == 1'b1, "R2 readback select", cfg_err, 1);
        wr(2'd3, 8'h00); chk(cfg_err == 1'b0, "R2 latch accepted", cfg_err, 0);
        wr(2'd3, 8'h10); chk(cfg_err == 1'b1, "R3 access 01", cfg_err, 1);
        wr(2'd3, 8'h31); chk(cfg_err == 1'b1, "R3 bcd", cfg_err, 1);
        wr(2'd3, 8'h34); chk(cfg_err == 1'b0, "R2 valid mode2", cfg_err, 0);
    endtask

    task automatic t_mode0;
        logic [7:0] d0, d1;
        wr(2'd3, 8'h30); chk(cfg_err == 1'b0, "R2 valid mode0", cfg_err, 0);
        wr(2'd3, 8'h32); chk(cfg_err == 1'b1, "R3 mode1 refused", cfg_err, 1);
        wr(2'd0, 8'd3); wr(2'd0, 8'd0);
        repeat (2*DIV - 1) @(negedge clk);
        chk(cnt_out[0] == 1'b0, "R9 low before terminal", cnt_out[0], 0);
        repeat (DIV + 2) @(negedge clk);
        chk(cnt_out[0] == 1'b1, "R9 high at terminal (R3 mode kept)", cnt_out[0], 1);
        repeat (40) @(negedge clk);
        chk(cnt_out[0] == 1'b1, "R9 stays high", cnt_out[0], 1);
        wr(2'd0, 8'd0);
        chk(cnt_out[0] == 1'b0, "R7 low write drops output", cnt_out[0], 0);
        wr(2'd0, 8'd0);
        repeat (40) @(negedge clk);
        chk(cnt_out[0] == 1'b0, "R8 zero reload stays stopped", cnt_out[0], 0);
        rd(2'd0, d0); rd(2'd0, d1);
        chk({d1, d0} == 16'h0000, "R8 zero count frozen", {d1, d0}, 0);
    endtask

    task automatic t_mode2;
        int n, lo, hi;
        wr(2'd3, 8'h74); wr(2'd1, 8'd5); wr(2'd1, 8'd0);
        chk(cnt_out[1] == 1'b1, "R8 mode2 starts high", cnt_out[1], 1);
        wait_lvl(1, 1'b0, n);
        wait_lvl(1, 1'b1, lo);
        chk(lo == DIV, "R10 one-tick low pulse", lo, DIV);
        wait_lvl(1, 1'b0, hi);
        chk(lo + hi == 5*DIV, "R12 period N*TICK_DIV", lo + hi, 5*DIV);
    endtask

    task automatic t_mode3;
        int n, lo, hi;
        logic [7:0] d;
        wr(2'd3, 8'hB6); wr(2'd2, 8'd5); wr(2'd2, 8'd0);
        wait_lvl(2, 1'b0, n);
        wait_lvl(2, 1'b1, lo);
        chk(lo == 2*DIV, "R11 low half floor(N/2)", lo, 2*DIV);
        wait_lvl(2, 1'b0, hi);
        chk(hi == 3*DIV, "R11 high half ceil(N/2)", hi, 3*DIV);
        rd(2'd3, d);
        chk(d == 8'h00, "R13 status low", d, 8'h00);
        wait_lvl(2, 1'b1, n);
        rd(2'd3, d);
        chk(d == 8'h20, "R13 status high", d, 8'h20);
    endtask

    task automatic t_latch;
        logic [7:0] d0, d1;
        wr(2'd3, 8'h74); wr(2'd1, 8'h34); wr(2'd1, 8'h12);
        chk(cnt_out[1] == 1'b1, "R8 running high", cnt_out[1], 1);
        wr(2'd1, 8'h56);
        chk(cnt_out[1] == 1'b0, "R7 low write stops", cnt_out[1], 0);
        repeat (30) @(negedge clk);
        rd(2'd1, d0); rd(2'd1, d1);
        chk({d1, d0} == 16'h1256, "R6 live read low then high", {d1, d0}, 16'h1256);
        wr(2'd3, 8'h40); chk(cfg_err == 1'b0, "R2 latch no error", cfg_err, 0);
        wr(2'd1, 8'h00);
        wr(2'd3, 8'h40);
        repeat (20) @(negedge clk);
        rd(2'd1, d0); rd(2'd1, d1);
        chk({d1, d0} == 16'h1256, "R4 R5 held value", {d1, d0}, 16'h1256);
        wr(2'd1, 8'h77);
        rd(2'd1, d0); rd(2'd1, d1);
        chk({d1, d0} == 16'h0077, "R4 latch released", {d1, d0}, 16'h0077);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_errors();
        t_mode0();
        t_mode2();
        t_mode3();
        t_latch();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule